// File: doc/BRIEF.md
# Cascaded Clock-Enable Strobe Tree

This block turns a fast reference clock into three nested enable strobes for a CPU domain, a system bus domain and a peripheral bus domain. It does not gate or generate clocks. Every flop runs on the one reference clock, and each output is a single-cycle strobe that downstream logic uses as a clock enable. The root of the tree is a tick input. A bypass pin chooses between the PLL-side tick and the crystal-side tick. A source pin can add a fractional stage that lets three of every four root ticks pass.

Three counting stages follow the root, one after another. The CPU stage divides the root by one plus a 2-bit field. The bus stage divides the CPU strobe by one plus a second 2-bit field. The peripheral stage halves the bus strobe. Each stage counts only the pulses of the stage above it, so the strobes stay phase-locked: a slower strobe is high only on cycles when every faster strobe is also high.

A new divider value is taken up only when its stage wraps, so a period is never cut short. All three strobes come from one output register and appear one cycle after the root tick that causes them. There is no data flow here, so every pin is a plain level or pulse with no handshake.

Top module: `clk_strobe_tree`

## Requirements
- R1: With `bypass` low, the root tick is `pll_tick`, and `xtal_tick` has no effect on the strobes.
- R2: With `bypass` high, the root tick is `xtal_tick`, and `pll_tick` has no effect on the strobes.
- R3: With `src_sel` high, a four-state phase counter advances on each selected tick. The tick seen in the fourth phase (phase 3) is dropped and the other three pass. After reset the first tick passes. With `src_sel` low, every selected tick passes.
- R4: `cpu_stb` pulses once for every (1 + `cpu_div`) root ticks, with `cpu_div` read as unsigned 0..3.
- R5: `ahb_stb` pulses once for every (1 + `ahb_div`) CPU strobes, with `ahb_div` read as unsigned 0..3.
- R6: `ipg_stb` pulses once for every two bus strobes.
- R7: `ahb_stb` is high only when `cpu_stb` is high, and `ipg_stb` is high only when `ahb_stb` is high.
- R8: A divider field that changes in mid-period takes effect only after that stage's current period ends. The old period finishes at full length.
- R9: While `rst` is high at a clock edge, all counters clear and every strobe is low after that edge. The first root tick after reset makes all three strobes pulse in the same cycle.
- R10: Each strobe is registered and goes high in the cycle right after the clock edge at which its root tick was sampled. A cycle with no root tick gives no strobe in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| pll_tick | input | 1 | Root tick from the PLL side |
| xtal_tick | input | 1 | Root tick from the crystal side |
| bypass | input | 1 | 1 selects `xtal_tick` as the root |
| src_sel | input | 1 | 1 inserts the three-of-four stage |
| cpu_div | input | 2 | CPU divide field, ratio 1 + value |
| ahb_div | input | 2 | Bus divide field, ratio 1 + value |
| cpu_stb | output | 1 | CPU enable strobe |
| ahb_stb | output | 1 | Bus enable strobe |
| ipg_stb | output | 1 | Peripheral enable strobe |

## Verification
The bench runs all 64 combinations of bypass, source and the two divider fields. For each one it counts strobes over a window of 1152 root ticks, a length that divides evenly for every ratio. In that run `pll_tick` pulses every cycle and `xtal_tick` every second cycle. A wrong root therefore shows up as a doubled or halved count, and a wrong swallow ratio shows up as a 3/4 error. Because the counts are exact, an off-by-one in any stage's terminal count is caught. A directed run that changes the CPU field in mid-period separates deferred uptake (a gap of four, then one) from immediate uptake. A reset run checks that all three strobes first appear together.

// File: rtl/strobe_tree_pkg.sv
package strobe_tree_pkg;
  localparam int DIV_W     = 2;
  localparam int STAGES    = 3;
  localparam int IPG_DIV   = 1;
  localparam int SWALLOW_N = 4;
  typedef logic [DIV_W-1:0] div_t;
endpackage

// File: rtl/root_select.sv
module root_select #(
  parameter int SWALLOW_N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pll_tick,
  input  logic xtal_tick,
  input  logic bypass,
  input  logic src_sel,
  output logic root_tick
);
  localparam int PH_W = (SWALLOW_N > 1) ? $clog2(SWALLOW_N) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SWALLOW_N - 1);

  logic            sel_tick;
  logic [PH_W-1:0] ph;

  assign sel_tick  = bypass ? xtal_tick : pll_tick;
  assign root_tick = sel_tick && !(src_sel && ph == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= '0;
    end else if (sel_tick && src_sel) begin
      ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
    end
  end

  AST_PH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(sel_tick && src_sel) |=> $stable(ph)); // R3
  AST_PH_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (sel_tick && src_sel && ph != PH_LAST) |=> ph != '0); // R3
endmodule

// File: rtl/stage_div.sv
module stage_div #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_in,
  input  logic [W-1:0] div_in,
  output logic         en_out
);
  logic [W-1:0] cnt;
  logic [W-1:0] lim;
  logic         wrap;

  assign wrap   = en_in && (cnt == lim);
  assign en_out = en_in && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      lim <= div_in;
    end else if (en_in) begin
      if (cnt == lim) begin
        cnt <= '0;
        lim <= div_in;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_LIM_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(lim)); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= lim); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en_in |=> $stable(cnt)); // R4
endmodule

// File: rtl/clk_strobe_tree.sv
module clk_strobe_tree
  import strobe_tree_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pll_tick,
  input  logic       xtal_tick,
  input  logic       bypass,
  input  logic       src_sel,
  input  logic [1:0] cpu_div,
  input  logic [1:0] ahb_div,
  output logic       cpu_stb,
  output logic       ahb_stb,
  output logic       ipg_stb
);
  logic [STAGES:0]   chain;
  div_t              stage_div_v [STAGES];
  logic [STAGES-1:0] stb_q;

  root_select #(.SWALLOW_N(SWALLOW_N)) u_root (
    .clk(clk), .rst(rst), .pll_tick(pll_tick), .xtal_tick(xtal_tick),
    .bypass(bypass), .src_sel(src_sel), .root_tick(chain[0])
  );

  assign stage_div_v[0] = cpu_div;
  assign stage_div_v[1] = ahb_div;
  assign stage_div_v[2] = div_t'(IPG_DIV);

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    stage_div #(.W(DIV_W)) u_div (
      .clk(clk), .rst(rst), .en_in(chain[g]),
      .div_in(stage_div_v[g]), .en_out(chain[g+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) stb_q <= '0;
    else     stb_q <= chain[STAGES:1];
  end

  assign cpu_stb = stb_q[0];
  assign ahb_stb = stb_q[1];
  assign ipg_stb = stb_q[2];

  AST_AHB_IN_CPU: assert property (@(posedge clk) disable iff (rst)
    ahb_stb |-> cpu_stb); // R7
  AST_IPG_IN_AHB: assert property (@(posedge clk) disable iff (rst)
    ipg_stb |-> ahb_stb); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!cpu_stb && !ahb_stb && !ipg_stb)); // R9
  AST_NO_TICK_NO_STB: assert property (@(posedge clk) disable iff (rst)
    !(bypass ? xtal_tick : pll_tick) |=> !cpu_stb); // R10
endmodule

// File: tb/clk_strobe_tree_tb_top.sv
`timescale 1ns/1ps
module clk_strobe_tree_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pll_tick = 1'b0, xtal_tick = 1'b0, bypass = 1'b0, src_sel = 1'b0;
  logic [1:0] cpu_div = '0, ahb_div = '0;
  logic cpu_stb, ahb_stb, ipg_stb;
  int total = 0, bad = 0, nest_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clk_strobe_tree dut_i (
    .clk(clk), .rst(rst), .pll_tick(pll_tick), .xtal_tick(xtal_tick),
    .bypass(bypass), .src_sel(src_sel), .cpu_div(cpu_div), .ahb_div(ahb_div),
    .cpu_stb(cpu_stb), .ahb_stb(ahb_stb), .ipg_stb(ipg_stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pll_tick = 1'b0; xtal_tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // R9 R10: quiet in reset, all strobes together on the first tick
  task automatic t_reset();
    cpu_div = 2'd2; ahb_div = 2'd3; bypass = 1'b0; src_sel = 1'b1;
    @(negedge clk);
    rst = 1'b1; pll_tick = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check({cpu_stb, ahb_stb, ipg_stb} == 3'b000, "R9 reset quiet",
          {cpu_stb, ahb_stb, ipg_stb}, 0);
    rst = 1'b0; pll_tick = 1'b1;
    @(negedge clk);
    check({cpu_stb, ahb_stb, ipg_stb} == 3'b111, "R9 R10 first strobes together",
          {cpu_stb, ahb_stb, ipg_stb}, 7);
    pll_tick = 1'b0;
    @(negedge clk);
    check(cpu_stb == 1'b0, "R10 no tick no strobe", cpu_stb, 0);
  endtask

  // R3: pass pattern 1,1,1,0 with unit divide
  task automatic t_swallow();
    int pat = 0;
    cpu_div = 2'd0; ahb_div = 2'd0; bypass = 1'b0; src_sel = 1'b1;
    do_reset();
    for (int i = 0; i < 9; i++) begin
      pll_tick = (i < 8);
      @(negedge clk);
      if (i < 8) pat = (pat << 1) | int'(cpu_stb);
    end
    check(pat == 8'b1110_1110, "R3 three of four pattern", pat, 8'b1110_1110);
  endtask

  // R1 R2 R3 R4 R5 R6 R7: exact strobe counts over 1152 root ticks
  task automatic t_ratio(input bit byp, input bit src, input int cd, input int ad);
    int w, rt, e_cpu, e_ahb, e_ipg;
    int n_cpu = 0, n_ahb = 0, n_ipg = 0;
    bypass = byp; src_sel = src; cpu_div = 2'(cd); ahb_div = 2'(ad);
    do_reset();
    w  = byp ? 2304 : 1152;
    rt = src ? 864 : 1152;
    e_cpu = rt / (cd + 1);
    e_ahb = e_cpu / (ad + 1);
    e_ipg = e_ahb / 2;
    for (int i = 0; i < w + 3; i++) begin
      pll_tick  = (i < w);
      xtal_tick = (i < w) && (i % 2 == 0);
      @(negedge clk);
      n_cpu += int'(cpu_stb);
      n_ahb += int'(ahb_stb);
      n_ipg += int'(ipg_stb);
      if ((ahb_stb && !cpu_stb) || (ipg_stb && !ahb_stb)) nest_bad++;
    end
    check(n_cpu == e_cpu, $sformatf("R4 R1 R2 R3 cpu byp=%0d src=%0d cd=%0d", byp, src, cd),
          n_cpu, e_cpu);
    check(n_ahb == e_ahb, $sformatf("R5 ahb cd=%0d ad=%0d", cd, ad), n_ahb, e_ahb);
    check(n_ipg == e_ipg, "R6 ipg half of ahb", n_ipg, e_ipg);
  endtask

  // R8: field change mid-period is deferred to the wrap
  task automatic t_defer();
    int idx = 0, s0 = -1, s1 = -1, s2 = -1;
    cpu_div = 2'd3; ahb_div = 2'd0; bypass = 1'b0; src_sel = 1'b0;
    do_reset();
    pll_tick = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      idx++;
      if (cpu_stb) begin
        if (s0 < 0) begin
          s0 = idx; cpu_div = 2'd0;
        end else if (s1 < 0) s1 = idx;
        else if (s2 < 0) s2 = idx;
      end
    end
    pll_tick = 1'b0;
    check(s1 - s0 == 4, "R8 old period completes", s1 - s0, 4);
    check(s2 - s1 == 1, "R8 new ratio after wrap", s2 - s1, 1);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_swallow();
    t_defer();
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 2; s++)
        for (int c = 0; c < 4; c++)
          for (int a = 0; a < 4; a++)
            t_ratio(b[0], s[0], c, a);
    check(nest_bad == 0, "R7 nesting", nest_bad, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule